// File: doc/BRIEF.md
# PRBS Bit Error Receiver and Counter

This block checks a 2^15-1 pseudo-random bit sequence carried on one serial input stream of a time-division multiplexed frame. Software programs the stream to watch, the first channel to watch and the number of consecutive channels that carry the sequence. Each clock is one bit slot, and the frame position arrives with it as a channel index. A frame pulse marks the first bit of channel 0. Only the bits of the programmed stream inside the programmed run of channels are examined.

The receiver synchronises to the incoming sequence without a shared seed. It fills a 15-bit register from the first examined bits. From then on it predicts every bit from the recurrence and compares the prediction with the received bit. Each mismatch adds one to a saturating error count. A burst of errors inside one 15-bit span is read as lost alignment: the receiver then drops its sync indication and fills the register again. One control input starts and stops checking, in step with the transmitter elsewhere on the chip. A separate clear input zeroes the count.

Top module: `prbs_err_rx`

## Requirements
- R1: After reset, `err_cnt_o` is 0 and `sync_o` is 0.
- R2: Only bits of stream `start_stream_i` in channels `start_chan_i` to `start_chan_i + len_i - 1` are examined, with no wrap past the last channel. A length of 0 examines nothing. Bits of other streams and other channels have no effect on count or sync.
- R3: After `run_i` rises, examination starts at the first slot where `frame_i` is high (channel 0, first bit). Window slots seen before that pulse are ignored.
- R4: The first 15 examined bits fill the reference register. `sync_o` rises after the 15th of them. The expected sequence obeys b[n] = b[n-14] XOR b[n-15].
- R5: Once in sync, each examined bit that differs from the predicted bit raises `err_cnt_o` by exactly one. The prediction runs on from the predicted bits, so one corrupted bit gives one error.
- R6: When the errors among the current compared bit and the 14 compared before it exceed `ERR_LIMIT`, `sync_o` falls and the next 15 examined bits refill the register. The error that triggers the loss is still counted.
- R7: `err_cnt_o` saturates at all ones and never wraps.
- R8: A high `clr_i` zeroes `err_cnt_o` at the next edge. A clear wins over an increment in the same cycle.
- R9: While `run_i` is low, `sync_o` is 0 from the next edge on, `err_cnt_o` holds its value, and all input bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock, one bit slot per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | NUM_STREAMS | Serial data, one bit per input stream |
| frame_i | input | 1 | High in the first bit slot of channel 0 |
| chan_i | input | $clog2(NUM_CH) | Channel index of the current bit slot |
| start_stream_i | input | $clog2(NUM_STREAMS) | Stream that carries the sequence |
| start_chan_i | input | $clog2(NUM_CH) | First channel of the examined run |
| len_i | input | $clog2(NUM_CH+1) | Number of consecutive channels examined |
| run_i | input | 1 | Start (1) or stop (0) checking |
| clr_i | input | 1 | Zero the error count |
| err_cnt_o | output | CNT_W | Saturating count of mismatched bits |
| sync_o | output | 1 | Reference register filled and aligned |

## Verification
The hardest state to reach from the ports is loss of alignment. It needs more than `ERR_LIMIT` errors packed into 15 compared bits, while the sequence keeps running so the receiver can refill. The bench flips exact bit positions inside the window: a run of exactly `ERR_LIMIT` consecutive errors that must leave sync up, then one more, placed so that the refill spans a frame boundary. Saturation is reached by sending the inverted sequence. The inverted sequence does not obey the recurrence, so every compared bit after a fill mismatches, and the receiver keeps losing and refilling until the count pins at all ones.

// File: rtl/prbs_rx_pkg.sv
package prbs_rx_pkg;
  localparam int SEQ_LEN = 15;
  localparam int TAP_A   = 14;
  localparam int TAP_B   = 13;
  localparam int HIST_W  = SEQ_LEN - 1;
  localparam int FILL_W  = $clog2(SEQ_LEN);

  function automatic logic pred_bit(input logic [SEQ_LEN-1:0] s);
    return s[TAP_A] ^ s[TAP_B];
  endfunction
endpackage

// File: rtl/prbs_rx_window.sv
module prbs_rx_window #(
  parameter int NUM_STREAMS = 8,
  parameter int NUM_CH      = 128,
  localparam int SS_W  = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int LEN_W = $clog2(NUM_CH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_STREAMS-1:0] ser_i,
  input  logic                   frame_i,
  input  logic [CH_W-1:0]        chan_i,
  input  logic [SS_W-1:0]        start_stream_i,
  input  logic [CH_W-1:0]        start_chan_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic                   run_i,
  output logic                   bit_v_o,
  output logic                   bit_d_o
);
  logic [NUM_STREAMS-1:0] pick;
  logic                   sel_bit;
  logic [CH_W:0]          offs;
  logic                   in_range;
  logic                   hit;
  logic                   armed_q, bit_v_q, bit_d_q;

  // one-hot stream select
  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_pick
    assign pick[g] = ser_i[g] & (start_stream_i == SS_W'(g));
  end
  assign sel_bit = |pick;

  always_comb begin
    offs     = {1'b0, chan_i} - {1'b0, start_chan_i};
    in_range = (chan_i >= start_chan_i) && (int'(offs) < int'(len_i));
    hit      = run_i & (armed_q | frame_i) & in_range;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      bit_v_q <= 1'b0;
      bit_d_q <= 1'b0;
    end else begin
      if (!run_i)       armed_q <= 1'b0;
      else if (frame_i) armed_q <= 1'b1;
      bit_v_q <= hit;
      bit_d_q <= sel_bit;
    end
  end

  assign bit_v_o = bit_v_q & run_i;
  assign bit_d_o = bit_d_q;
endmodule

// File: rtl/prbs_rx_track.sv
module prbs_rx_track
  import prbs_rx_pkg::*;
#(
  parameter int ERR_LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic bit_v_i,
  input  logic bit_d_i,
  output logic err_o,
  output logic sync_o
);
  localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(SEQ_LEN - 1);

  logic [SEQ_LEN-1:0] sreg_q;
  logic [HIST_W-1:0]  hist_q;
  logic [FILL_W-1:0]  fill_q;
  logic               lock_q;
  logic               exp_b, mism, lose;
  int                 err_sum;

  always_comb begin
    exp_b   = pred_bit(sreg_q);
    mism    = bit_v_i & lock_q & (bit_d_i ^ exp_b);
    err_sum = $countones(hist_q) + int'(mism);
    lose    = mism && (err_sum > ERR_LIMIT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      hist_q <= '0;
      fill_q <= '0;
      lock_q <= 1'b0;
    end else if (!run_i) begin
      hist_q <= '0;
      fill_q <= '0;
      lock_q <= 1'b0;
    end else if (bit_v_i) begin
      if (!lock_q) begin
        sreg_q <= {sreg_q[SEQ_LEN-2:0], bit_d_i};
        if (fill_q == FILL_LAST) begin
          lock_q <= 1'b1;
          fill_q <= '0;
        end else begin
          fill_q <= fill_q + 1'b1;
        end
      end else if (lose) begin
        lock_q <= 1'b0;
        fill_q <= '0;
        hist_q <= '0;
      end else begin
        // run on from the prediction: one bad bit, one error
        sreg_q <= {sreg_q[SEQ_LEN-2:0], exp_b};
        hist_q <= {hist_q[HIST_W-2:0], mism};
      end
    end
  end

  assign err_o  = mism;
  assign sync_o = lock_q;
endmodule

// File: rtl/prbs_rx_errcnt.sv
module prbs_rx_errcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (inc_i && !(&cnt_q)) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/prbs_err_rx.sv
module prbs_err_rx #(
  parameter int NUM_STREAMS = 8,
  parameter int NUM_CH      = 128,
  parameter int CNT_W       = 16,
  parameter int ERR_LIMIT   = 4,
  localparam int SS_W  = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int LEN_W = $clog2(NUM_CH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_STREAMS-1:0] ser_i,
  input  logic                   frame_i,
  input  logic [CH_W-1:0]        chan_i,
  input  logic [SS_W-1:0]        start_stream_i,
  input  logic [CH_W-1:0]        start_chan_i,
  input  logic [LEN_W-1:0]       len_i,
  input  logic                   run_i,
  input  logic                   clr_i,
  output logic [CNT_W-1:0]       err_cnt_o,
  output logic                   sync_o
);
  logic bit_v, bit_d, err_inc;

  prbs_rx_window #(
    .NUM_STREAMS(NUM_STREAMS),
    .NUM_CH     (NUM_CH)
  ) u_window (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ser_i         (ser_i),
    .frame_i       (frame_i),
    .chan_i        (chan_i),
    .start_stream_i(start_stream_i),
    .start_chan_i  (start_chan_i),
    .len_i         (len_i),
    .run_i         (run_i),
    .bit_v_o       (bit_v),
    .bit_d_o       (bit_d)
  );

  prbs_rx_track #(
    .ERR_LIMIT(ERR_LIMIT)
  ) u_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .bit_v_i(bit_v),
    .bit_d_i(bit_d),
    .err_o  (err_inc),
    .sync_o (sync_o)
  );

  prbs_rx_errcnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .inc_i (err_inc),
    .cnt_o (err_cnt_o)
  );
endmodule

// File: rtl/prbs_err_rx_chk.sv
module prbs_err_rx_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             clr_i,
  input logic             sync_o,
  input logic [CNT_W-1:0] err_cnt_o,
  input logic             bit_v,
  input logic             err_inc
);
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (err_cnt_o == '0)); // R8

  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && (&err_cnt_o)) |=> (&err_cnt_o)); // R7

  AST_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((err_cnt_o == $past(err_cnt_o)) ||
                ({1'b0, err_cnt_o} == {1'b0, $past(err_cnt_o)} + 1'b1))); // R5

  AST_OFF_NOSYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !sync_o); // R9

  AST_OFF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(err_cnt_o)); // R9

  AST_SYNC_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> $past(bit_v)); // R4

  AST_SYNC_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_o) |-> $past(!run_i || err_inc)); // R6
endmodule

bind prbs_err_rx prbs_err_rx_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_i    (run_i),
  .clr_i    (clr_i),
  .sync_o   (sync_o),
  .err_cnt_o(err_cnt_o),
  .bit_v    (bit_v),
  .err_inc  (err_inc)
);

// File: tb/prbs_err_rx_tb.sv
module prbs_err_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS    = 4;
  localparam int NCH   = 8;
  localparam int CW    = 8;
  localparam int LIMIT = 4;
  localparam int SS_W  = $clog2(NS);
  localparam int CH_W  = $clog2(NCH);
  localparam int LEN_W = $clog2(NCH + 1);

  typedef struct {
    int    cnt;
    bit    sync;
    bit    sync_dc;
    string tag;
  } exp_t;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [NS-1:0]    ser_i = '0;
  logic             frame_i = 1'b0;
  logic [CH_W-1:0]  chan_i = '0;
  logic [SS_W-1:0]  start_stream_i = '0;
  logic [CH_W-1:0]  start_chan_i = '0;
  logic [LEN_W-1:0] len_i = '0;
  logic             run_i = 1'b0;
  logic             clr_i = 1'b0;
  logic [CW-1:0]    err_cnt_o;
  logic             sync_o;

  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;
  exp_t q[$];
  logic [14:0] gen_q = 15'h0001;
  int   exp_cnt = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  prbs_err_rx #(
    .NUM_STREAMS(NS), .NUM_CH(NCH), .CNT_W(CW), .ERR_LIMIT(LIMIT)
  ) u_dut (
    .clk_i, .rst_ni, .ser_i, .frame_i, .chan_i, .start_stream_i,
    .start_chan_i, .len_i, .run_i, .clr_i, .err_cnt_o, .sync_o
  );

  // sequence source: b[n] = b[n-14] ^ b[n-15]
  function automatic logic gen_next();
    logic nb;
    nb    = gen_q[14] ^ gen_q[13];
    gen_q = {gen_q[13:0], nb};
    return nb;
  endfunction

  task automatic expect_now(input int cnt, input bit sync, input bit dc, input string tag);
    exp_t e;
    e.cnt = cnt; e.sync = sync; e.sync_dc = dc; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #1;
      frame_i = 1'b0;
      chan_i  = '0;
      ser_i   = NS'($urandom);
    end
  endtask

  // one full frame; flips index the examined bits of this frame
  task automatic run_frame(input logic [63:0] flips, input bit inv);
    int wb = 0;
    for (int ch = 0; ch < NCH; ch++) begin
      for (int b = 0; b < 8; b++) begin
        @(posedge clk_i); #1;
        chan_i  = CH_W'(ch);
        frame_i = (ch == 0 && b == 0);
        ser_i   = NS'($urandom);
        if (ch >= int'(start_chan_i) && ch < int'(start_chan_i) + int'(len_i)) begin
          ser_i[start_stream_i] = gen_next() ^ flips[wb] ^ inv;
          wb++;
        end
      end
    end
    idle(4);
  endtask

  task automatic pulse_clr();
    @(posedge clk_i); #1; clr_i = 1'b1;
    @(posedge clk_i); #1; clr_i = 1'b0;
    idle(2);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (int'(err_cnt_o) != e.cnt) begin
          n_fail++;
          $display("FAIL %s count: actual %0d expected %0d", e.tag, err_cnt_o, e.cnt);
        end else if (!e.sync_dc && sync_o != e.sync) begin
          n_fail++;
          $display("FAIL %s sync: actual %0b expected %0b", e.tag, sync_o, e.sync);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
      $finish;
    end
  end

  initial begin
    start_stream_i = 2'd2; start_chan_i = 3'd2; len_i = 4'd3;
    repeat (3) @(posedge clk_i);
    #1; rst_ni = 1'b1;
    expect_now(0, 0, 0, "R1 reset");
    idle(2);
    run_i = 1'b1;
    idle(2);

    run_frame(64'h0, 0);                       // R4 fill then compare 9 clean bits
    expect_now(exp_cnt, 1, 0, "R4 lock clean");
    idle(1);

    run_frame((64'h1 << 3) | (64'h1 << 10), 0); // R5 two isolated errors
    exp_cnt += 2;
    expect_now(exp_cnt, 1, 0, "R5 two single errors");
    idle(1);

    run_frame(64'h1, 0);                        // R5 error at first window bit
    exp_cnt += 1;
    expect_now(exp_cnt, 1, 0, "R5 first bit error");
    idle(1);

    run_frame(64'hF << 5, 0);                   // R6 exactly LIMIT errors, sync kept
    exp_cnt += 4;
    expect_now(exp_cnt, 1, 0, "R6 at limit");
    idle(1);

    run_frame(64'h1F << 10, 0);                 // R6 LIMIT+1 errors, refill 9 bits
    exp_cnt += 5;
    expect_now(exp_cnt, 0, 0, "R6 loss");
    idle(1);

    run_frame(64'h0, 0);                        // R6 refill completes, no new errors
    expect_now(exp_cnt, 1, 0, "R6 relock");
    idle(1);

    run_frame(64'h0, 0);                        // R2 other streams/channels random
    expect_now(exp_cnt, 1, 0, "R2 outside ignored");
    idle(1);

    pulse_clr();                                // R8
    exp_cnt = 0;
    expect_now(0, 1, 0, "R8 clear");
    idle(1);

    run_i = 1'b0;                               // R9
    idle(2);
    expect_now(0, 0, 0, "R9 stop drops sync");
    idle(1);
    run_frame(64'h0, 1);
    expect_now(0, 0, 0, "R9 stopped ignores bits");
    idle(1);

    // R3: window slots before the first frame pulse are junk
    start_stream_i = 2'd1; start_chan_i = 3'd1; len_i = 4'd6;
    idle(1);
    run_i = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk_i); #1;
      chan_i = start_chan_i; frame_i = 1'b0; ser_i = NS'($urandom);
    end
    idle(2);
    run_frame(64'h0, 0);
    expect_now(0, 1, 0, "R3 arm at frame pulse");
    idle(1);

    run_frame(64'h1 << 40, 0);                  // R2 new stream/channels/length
    exp_cnt += 1;
    expect_now(exp_cnt, 1, 0, "R2 reprogrammed window");
    idle(1);

    len_i = 4'd0;                               // R2 empty window
    idle(1);
    run_frame(64'h0, 1);
    expect_now(exp_cnt, 1, 0, "R2 zero length");
    len_i = 4'd6;
    idle(1);

    for (int f = 0; f < 70; f++) run_frame(64'h0, 1); // R7
    expect_now(255, 0, 1, "R7 saturate");
    idle(1);
    for (int f = 0; f < 3; f++) run_frame(64'h0, 1);
    expect_now(255, 0, 1, "R7 no wrap");
    idle(1);

    pulse_clr();
    expect_now(0, 0, 1, "R8 clear after saturation");
    idle(1);

    run_i = 1'b0; idle(2); run_i = 1'b1; idle(2);
    run_frame(64'h0, 0);
    exp_cnt = 0;
    expect_now(0, 1, 0, "R4 relock after restart");
    idle(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule